// File: doc/BRIEF.md
# Interrupt Collector with Identification Words

This block gathers up to sixteen level-type interrupt requests from devices on an add-on board into one active-low interrupt line for the host. Each request is brought into the clock domain by two flip-flops and then sets a sticky pending bit. A per-line disable bit keeps a pending line from reaching the host output. Software removes a pending bit by writing a one to that bit of a clear register and then writing zero to the same register. If the request is still active when the clear bit goes back to zero, the pending bit sets again.

The block also holds three constant identification words and a firmware revision word. Host software reads these to confirm the board is present before it enables anything. The block also has a small LED output register and a button input register.

All of these are on a simple synchronous register bus. A read strobe returns data one cycle later. A write strobe takes effect at the clock edge where it is sampled. Routine line numbers used by software are: 0 network controller, 1 and 2 the two serial ports, 3 and 4 the two buttons.

Top module: `dbg_irq_hub`

## Requirements
- R1: After reset the pending register (offset 0x10) reads 0x0000, the disable register (0x38) reads 0xFFFF, the LED output is 0 and `irq_n` is 1.
- R2: Offsets 0x40, 0x48 and 0x58 read 0xAAAA, 0x5555 and 0xCAFE. Offset 0x50 reads the revision parameter (default 0x0103).
- R3: A high level on `irq_src[n]` sets pending bit n within four clock edges. The bit stays set after the source falls, and other bits are unaffected.
- R4: A disable bit of 1 keeps its line off `irq_n`, and a 0 lets it through. `irq_n` is 0 exactly one cycle after a cycle in which some pending bit has its disable bit clear.
- R5: While bit n of the clear register (0x20) is 1, pending bit n reads 0, even with the source held high. After the clear register is written back to 0, a still-active source sets the bit again.
- R6: `irq_n` is 1 whenever no enabled line is pending, including after all pending enabled lines have been cleared.
- R7: A read of an offset that is not mapped returns 0x0000. Writes to the pending, identification, revision and button offsets change nothing.
- R8: The LED register (0x00) is read/write, and its value drives `led_out`.
- R9: The button register (0x08) returns the synchronized `btn_in` value in its low bits, with zeros above.
- R10: `bus_rdata` shows the addressed register in the cycle after `bus_re` is sampled high. It is 0x0000 in the cycle after a clock edge with `bus_re` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| irq_src | input | 16 | Level interrupt requests, line n on bit n |
| btn_in | input | 2 | Raw button levels |
| led_out | output | 16 | LED register value |
| irq_n | output | 1 | Active-low combined interrupt |

## Verification
The hardest case to reach from the ports is a clear pulse that arrives while its source is still asserted. The pending bit must read zero during the pulse and then come back once the clear bit drops. The bench holds a request high, unmasks it, writes the clear bit, and reads the pending register with the clear still in force. It then writes the clear register back to zero and reads again after the synchronizer delay. A second case checks that a masked line never reaches `irq_n`, by holding a pending line while its disable bit is toggled.

// File: rtl/dbg_irq_pkg.sv
package dbg_irq_pkg;
  localparam logic [7:0] OFF_LED   = 8'h00;
  localparam logic [7:0] OFF_BTN   = 8'h08;
  localparam logic [7:0] OFF_PEND  = 8'h10;
  localparam logic [7:0] OFF_CLR   = 8'h20;
  localparam logic [7:0] OFF_DIS   = 8'h38;
  localparam logic [7:0] OFF_ID0   = 8'h40;
  localparam logic [7:0] OFF_ID1   = 8'h48;
  localparam logic [7:0] OFF_REV   = 8'h50;
  localparam logic [7:0] OFF_ID2   = 8'h58;
  localparam logic [15:0] ID0_WORD = 16'hAAAA;
  localparam logic [15:0] ID1_WORD = 16'h5555;
  localparam logic [15:0] ID2_WORD = 16'hCAFE;
endpackage

// File: rtl/dbg_sync_bank.sv
module dbg_sync_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= d[i];
        sync_q <= meta_q;
      end
    end
    assign q[i] = sync_q;
  end
endmodule

// File: rtl/dbg_irq_core.sv
module dbg_irq_core #(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] src_sync,
  input  logic                 dis_we,
  input  logic                 clr_we,
  input  logic [NUM_LINES-1:0] wdata,
  output logic [NUM_LINES-1:0] pend_q,
  output logic [NUM_LINES-1:0] dis_q,
  output logic [NUM_LINES-1:0] clr_q,
  output logic                 irq_n
);
  logic [NUM_LINES-1:0] live;
  assign live = pend_q & ~dis_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      dis_q  <= '1;
      clr_q  <= '0;
      irq_n  <= 1'b1;
    end else begin
      if (dis_we) dis_q <= wdata;
      if (clr_we) clr_q <= wdata;
      pend_q <= (pend_q | src_sync) & ~clr_q;
      irq_n  <= ~(|live);
    end
  end
endmodule

// File: rtl/dbg_read_mux.sv
module dbg_read_mux
  import dbg_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] REV = 16'h0103
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] led,
  input  logic [DATA_W-1:0] btn,
  input  logic [DATA_W-1:0] pend,
  input  logic [DATA_W-1:0] clr,
  input  logic [DATA_W-1:0] dis,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    case (addr)
      ADDR_W'(OFF_LED):  sel = led;
      ADDR_W'(OFF_BTN):  sel = btn;
      ADDR_W'(OFF_PEND): sel = pend;
      ADDR_W'(OFF_CLR):  sel = clr;
      ADDR_W'(OFF_DIS):  sel = dis;
      ADDR_W'(OFF_ID0):  sel = DATA_W'(ID0_WORD);
      ADDR_W'(OFF_ID1):  sel = DATA_W'(ID1_WORD);
      ADDR_W'(OFF_REV):  sel = REV;
      ADDR_W'(OFF_ID2):  sel = DATA_W'(ID2_WORD);
      default:           sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= re ? sel : '0;
  end
endmodule

// File: rtl/dbg_irq_hub.sv
module dbg_irq_hub
  import dbg_irq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int NUM_LINES = 16,
  parameter int BTN_W     = 2,
  parameter logic [DATA_W-1:0] REV = 16'h0103
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_LINES-1:0] irq_src,
  input  logic [BTN_W-1:0]  btn_in,
  output logic [DATA_W-1:0] led_out,
  output logic              irq_n
);
  logic [NUM_LINES-1:0] src_sync, pend_q, dis_q, clr_q;
  logic [BTN_W-1:0]     btn_sync;
  logic [DATA_W-1:0]    led_q, btn_x, pend_x, dis_x, clr_x;
  logic                 dis_we, clr_we, led_we;

  assign dis_we = bus_we && (bus_addr == ADDR_W'(OFF_DIS));
  assign clr_we = bus_we && (bus_addr == ADDR_W'(OFF_CLR));
  assign led_we = bus_we && (bus_addr == ADDR_W'(OFF_LED));

  dbg_sync_bank #(.W(NUM_LINES)) u_src_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_src), .q(src_sync));

  dbg_sync_bank #(.W(BTN_W)) u_btn_sync (
    .clk(clk), .rst_n(rst_n), .d(btn_in), .q(btn_sync));

  dbg_irq_core #(.NUM_LINES(NUM_LINES)) u_core (
    .clk(clk), .rst_n(rst_n), .src_sync(src_sync),
    .dis_we(dis_we), .clr_we(clr_we), .wdata(bus_wdata[NUM_LINES-1:0]),
    .pend_q(pend_q), .dis_q(dis_q), .clr_q(clr_q), .irq_n(irq_n));

  always_ff @(posedge clk) begin
    if (!rst_n)      led_q <= '0;
    else if (led_we) led_q <= bus_wdata;
  end
  assign led_out = led_q;

  always_comb begin
    btn_x  = '0;
    pend_x = '0;
    dis_x  = '0;
    clr_x  = '0;
    btn_x[BTN_W-1:0]      = btn_sync;
    pend_x[NUM_LINES-1:0] = pend_q;
    dis_x[NUM_LINES-1:0]  = dis_q;
    clr_x[NUM_LINES-1:0]  = clr_q;
  end

  dbg_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REV(REV)) u_rd (
    .clk(clk), .rst_n(rst_n), .re(bus_re), .addr(bus_addr),
    .led(led_q), .btn(btn_x), .pend(pend_x), .clr(clr_x), .dis(dis_x),
    .rdata(bus_rdata));
endmodule

// File: rtl/dbg_irq_hub_chk.sv
module dbg_irq_hub_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int NUM_LINES = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_re,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic [NUM_LINES-1:0] pend_q,
  input logic [NUM_LINES-1:0] dis_q,
  input logic [NUM_LINES-1:0] clr_q,
  input logic                 irq_n
);
  // R2
  id0_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == ADDR_W'(8'h40)) |=> bus_rdata == DATA_W'(16'hAAAA));

  // R3
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend_q) & ~pend_q & ~$past(clr_q)) == '0);

  // R4
  irq_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~dis_q) != '0) |=> !irq_n);

  // R6
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~dis_q) == '0) |=> irq_n);

  // R5
  clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_q) |=> ((pend_q & $past(clr_q)) == '0));

  // R10
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> bus_rdata == '0);
endmodule

bind dbg_irq_hub dbg_irq_hub_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LINES(NUM_LINES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_re(bus_re), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .pend_q(pend_q), .dis_q(dis_q), .clr_q(clr_q),
  .irq_n(irq_n));

// File: tb/dbg_irq_hub_test.sv
module dbg_irq_hub_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [15:0] bus_rdata;
  logic [15:0] irq_src = '0;
  logic [1:0]  btn_in = '0;
  logic [15:0] led_out;
  logic        irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dbg_irq_hub uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .irq_src(irq_src), .btn_in(btn_in), .led_out(led_out), .irq_n(irq_n));

  // {offset, expected word}
  localparam logic [23:0] RD_TAB [8] = '{
    {8'h40, 16'hAAAA}, {8'h48, 16'h5555}, {8'h58, 16'hCAFE}, {8'h50, 16'h0103},
    {8'h60, 16'h0000}, {8'h68, 16'h0000}, {8'h18, 16'h0000}, {8'hFE, 16'h0000}};

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_addr = a;
    bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    v = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_wdata = d;
    bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x0000 expected 0x0001");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check(irq_n == 1'b1, "R1 irq_n", {15'd0, irq_n}, 16'h0001);
    check(led_out == 16'h0, "R1 led_out", led_out, 16'h0000);
    rd(8'h10, v); check(v == 16'h0000, "R1 pending", v, 16'h0000);
    rd(8'h38, v); check(v == 16'hFFFF, "R1 disable", v, 16'hFFFF);

    // R2, R7 table walk: identification words and unmapped offsets
    for (int i = 0; i < 8; i++) begin
      rd(RD_TAB[i][23:16], v);
      check(v == RD_TAB[i][15:0], "R2/R7 table read", v, RD_TAB[i][15:0]);
    end

    // R10 idle cycle after a read returns zero
    idle(1);
    check(bus_rdata == 16'h0, "R10 idle rdata", bus_rdata, 16'h0000);

    // R3 latch while masked, R4 masked line keeps irq_n high
    irq_src = 16'h0008;
    idle(5);
    rd(8'h10, v); check(v == 16'h0008, "R3 latch", v, 16'h0008);
    check(irq_n == 1'b1, "R4 masked", {15'd0, irq_n}, 16'h0001);
    irq_src = 16'h0;
    idle(5);
    rd(8'h10, v); check(v == 16'h0008, "R3 sticky", v, 16'h0008);

    // R4 enabling the line asserts irq_n, disabling releases it
    wr(8'h38, 16'hFFF7);
    idle(1);
    check(irq_n == 1'b0, "R4 enabled", {15'd0, irq_n}, 16'h0000);
    wr(8'h38, 16'hFFFF);
    idle(1);
    check(irq_n == 1'b1, "R4 disabled", {15'd0, irq_n}, 16'h0001);

    // R5 clear sequence on an inactive line, then R6 irq_n stays high
    wr(8'h38, 16'hFFD7);
    wr(8'h20, 16'h0008);
    rd(8'h10, v); check(v == 16'h0000, "R5 cleared", v, 16'h0000);
    wr(8'h20, 16'h0000);
    idle(4);
    rd(8'h10, v); check(v == 16'h0000, "R5 stays clear", v, 16'h0000);
    check(irq_n == 1'b1, "R6 none pending", {15'd0, irq_n}, 16'h0001);

    // R5 clear while source still active: held zero, then set again
    irq_src = 16'h0020;
    idle(5);
    check(irq_n == 1'b0, "R4 line5 live", {15'd0, irq_n}, 16'h0000);
    wr(8'h20, 16'h0020);
    rd(8'h10, v); check(v == 16'h0000, "R5 held by clear", v, 16'h0000);
    wr(8'h20, 16'h0000);
    idle(3);
    rd(8'h10, v); check(v == 16'h0020, "R5 re-set", v, 16'h0020);

    // R3 several lines at once, bit n for line n
    irq_src = 16'h8021;
    idle(5);
    rd(8'h10, v); check(v == 16'h8021, "R3 multi line", v, 16'h8021);
    irq_src = 16'h0;

    // R7 writes to read-only offsets are ignored
    wr(8'h10, 16'h0000);
    rd(8'h10, v); check(v == 16'h8021, "R7 pending ro", v, 16'h8021);
    wr(8'h40, 16'h1234);
    rd(8'h40, v); check(v == 16'hAAAA, "R7 id ro", v, 16'hAAAA);
    wr(8'h50, 16'h0000);
    rd(8'h50, v); check(v == 16'h0103, "R7 rev ro", v, 16'h0103);

    // R8 LED register
    wr(8'h00, 16'h5A3C);
    check(led_out == 16'h5A3C, "R8 led_out", led_out, 16'h5A3C);
    rd(8'h00, v); check(v == 16'h5A3C, "R8 readback", v, 16'h5A3C);

    // R9 button register, and write to it ignored
    btn_in = 2'b10;
    idle(3);
    wr(8'h08, 16'hFFFF);
    rd(8'h08, v); check(v == 16'h0002, "R9 buttons", v, 16'h0002);

    // R6 clear all, irq_n back high
    wr(8'h20, 16'hFFFF);
    wr(8'h20, 16'h0000);
    idle(2);
    check(irq_n == 1'b1, "R6 all cleared", {15'd0, irq_n}, 16'h0001);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule